// File: doc/BRIEF.md
# Board Control Register Bank

A 32-bit register bank that gathers a board's low-speed control and status into one 4 KiB word-addressed window. Software drives user LEDs, keeps a debug control word and a general-purpose control word, samples push buttons and slide switches, and reads two wall-clock style counters that advance once per second and a hundred times per second. Both rates are derived from the system clock by enable dividers whose ratios follow the `CLK_HZ` parameter.

Access is a single-cycle bus: address, write strobe, read strobe and write data are presented for one clock; read data and the error pulse are registered and appear the cycle after the access. The debug and switch words are build-time options. When one is left out, its offset behaves like any hole in the map. Writes never stall, and reads never return stale decode.

Top module: `sysctl_regbank`

## Requirements
- R1: Word offsets within the 4096-byte window are: LED 0x000, debug control 0x004, buttons 0x008, 1 Hz counter 0x010, 100 Hz counter 0x014, switches 0x028, general control 0x04C; `rdata_o` shows the read value on the cycle after `rd_en_i` is sampled.
- R2: A write to the LED word keeps only its low `NUM_LEDS` bits; bit i drives `led_o[i]` high-active, and the LED word reads back the masked value.
- R3: With `NUM_LEDS` = 0, LED writes have no effect: `led_o` stays 0 and the LED word reads 0.
- R4: The debug control word exists only when `HAS_DBGCTRL` = 1 and reads back what was written; the switch word exists only when `HAS_SWITCHES` = 1; when absent each behaves as an unmapped offset.
- R5: The general control word reads back the last value written and affects nothing else.
- R6: An access to any other offset (including misaligned ones) pulses `err_o` for exactly the cycle after the access; a read returns 0 and a write changes no state.
- R7: The counters increment by one every `CLK_HZ` cycles (1 Hz) and every `CLK_HZ/100` cycles (100 Hz).
- R8: Writing a counter loads the written value and restarts its divider, so the next increment falls a full period after the write edge.
- R9: Buttons and switches are read through a two-flop synchronizer, zero-extended above the input width.
- R10: Reset clears the LED, debug control, general control and both counters; `err_o` and `rdata_o` reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address within the window |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an unmapped access |
| led_o | output | max(NUM_LEDS,1) | LED drive, active high |
| btn_i | input | BTN_W | Asynchronous button inputs |
| sw_i | input | SW_W | Asynchronous switch inputs |

## Verification
The hardest case to reach is the divider restart on a counter load: the divider phase at the write is arbitrary, so only a read landing exactly on the last cycle before the first post-load increment, and another on the first cycle after it, can separate a restarted divider from a free-running one. The bench lowers `CLK_HZ` so the 100 Hz divider is ten cycles long, counts clock edges from the write edge to the read edge, and issues two back-to-back reads straddling that boundary. A second instance built without the optional words and with no LEDs receives the same bus traffic so absent-register faults and masked LED writes are seen side by side with the full build.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WIN_BYTES = 4096;
  localparam int unsigned ADDR_W    = $clog2(WIN_BYTES);

  localparam logic [ADDR_W-1:0] OFF_LED  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_DBG  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_BTN  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_T1   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_T100 = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_SW   = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_MISC = 12'h04C;

  localparam int unsigned NUM_RATES = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LED, SEL_DBG, SEL_BTN, SEL_T1, SEL_T100, SEL_SW, SEL_MISC
  } sel_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter bit HAS_DBGCTRL  = 1'b0,
  parameter bit HAS_SWITCHES = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    case (addr_i)
      OFF_LED:  sel_o = SEL_LED;
      OFF_DBG:  sel_o = HAS_DBGCTRL ? SEL_DBG : SEL_NONE;
      OFF_BTN:  sel_o = SEL_BTN;
      OFF_T1:   sel_o = SEL_T1;
      OFF_T100: sel_o = SEL_T100;
      OFF_SW:   sel_o = HAS_SWITCHES ? SEL_SW : SEL_NONE;
      OFF_MISC: sel_o = SEL_MISC;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sysctl_rate_cnt.sv
module sysctl_rate_cnt
  import sysctl_pkg::*;
#(
  parameter int unsigned DIV = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0]     div_q;
  logic [DATA_W-1:0] cnt_q;
  logic              tick;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= '0;               // restart phase on load
      cnt_q <= load_val_i;
    end else if (tick) begin
      div_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_LEDS     = 2,
  parameter bit          HAS_DBGCTRL  = 1'b0,
  parameter bit          HAS_SWITCHES = 1'b0,
  parameter int unsigned BTN_W        = 2,
  parameter int unsigned SW_W         = 4,
  parameter int unsigned CLK_HZ       = 50_000_000
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic                                 wr_en_i,
  input  logic                                 rd_en_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  output logic [DATA_W-1:0]                    rdata_o,
  output logic                                 err_o,
  output logic [((NUM_LEDS > 0) ? NUM_LEDS : 1)-1:0] led_o,
  input  logic [BTN_W-1:0]                     btn_i,
  input  logic [SW_W-1:0]                      sw_i
);
  sel_e              sel;
  logic              wr, rd;
  logic [DATA_W-1:0] led_word, dbg_q, misc_q, rd_mux, rdata_q;
  logic [DATA_W-1:0] tcnt [NUM_RATES];
  logic [BTN_W-1:0]  btn_s;
  logic [SW_W-1:0]   sw_s;
  logic              err_q;

  assign wr = wr_en_i;
  assign rd = rd_en_i && !wr_en_i;

  sysctl_decode #(.HAS_DBGCTRL(HAS_DBGCTRL), .HAS_SWITCHES(HAS_SWITCHES)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  sysctl_sync #(.W(BTN_W)) u_sync_btn (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_i), .q_o(btn_s));
  sysctl_sync #(.W(SW_W))  u_sync_sw  (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(sw_i),  .q_o(sw_s));

  // Time counters: index 0 is 1 Hz, index 1 is 100 Hz
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int unsigned RATE = (g == 0) ? 1 : 100;
    localparam int unsigned DIV  = (CLK_HZ / RATE > 0) ? CLK_HZ / RATE : 1;
    localparam sel_e        MYSEL = (g == 0) ? SEL_T1 : SEL_T100;
    sysctl_rate_cnt #(.DIV(DIV)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (wr && (sel == MYSEL)),
      .load_val_i (wdata_i),
      .cnt_o      (tcnt[g])
    );
  end

  // LEDs
  if (NUM_LEDS > 0) begin : g_led
    logic [NUM_LEDS-1:0] led_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    led_q <= '0;
      else if (wr && sel == SEL_LED)  led_q <= wdata_i[NUM_LEDS-1:0];
    end
    assign led_o    = led_q;
    assign led_word = DATA_W'(led_q);

    p_led_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr && sel == SEL_LED) |=> $stable(led_o));
  end else begin : g_noled
    assign led_o    = '0;
    assign led_word = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q  <= '0;
      misc_q <= '0;
    end else if (wr) begin
      if (sel == SEL_DBG)  dbg_q  <= wdata_i;
      if (sel == SEL_MISC) misc_q <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_LED:  rd_mux = led_word;
      SEL_DBG:  rd_mux = dbg_q;
      SEL_BTN:  rd_mux = DATA_W'(btn_s);
      SEL_T1:   rd_mux = tcnt[0];
      SEL_T100: rd_mux = tcnt[1];
      SEL_SW:   rd_mux = DATA_W'(sw_s);
      SEL_MISC: rd_mux = misc_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (wr || rd) && (sel == SEL_NONE);
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  p_err_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i || rd_en_i));

  p_err_rdata_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(rd_en_i && !wr_en_i)) |-> rdata_o == '0);

  p_misc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && sel == SEL_MISC) |=> $stable(misc_q));

  p_dbg_absent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_DBGCTRL |-> dbg_q == '0);
endmodule

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;
  localparam int unsigned CLK_HZ = 1000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  btn = '0;
  logic [3:0]  sw = '0;

  logic [31:0] rdata_a, rdata_b;
  logic        err_a, err_b;
  logic [1:0]  led_a;
  logic [0:0]  led_b;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysctl_regbank #(.NUM_LEDS(2), .HAS_DBGCTRL(1'b1), .HAS_SWITCHES(1'b1),
                   .BTN_W(2), .SW_W(4), .CLK_HZ(CLK_HZ)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata_a), .err_o(err_a), .led_o(led_a),
    .btn_i(btn), .sw_i(sw));

  sysctl_regbank #(.NUM_LEDS(0), .HAS_DBGCTRL(1'b0), .HAS_SWITCHES(1'b0),
                   .BTN_W(2), .SW_W(4), .CLK_HZ(CLK_HZ)) dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata_b), .err_o(err_b), .led_o(led_b),
    .btn_i(btn), .sw_i(sw));

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd2},  // R2 write LED
    '{1'b0, 12'h000, 32'h0,         32'h3,         1'b0, 4'd2},  // R2 masked readback
    '{1'b1, 12'h04C, 32'hA5A5_0F0F, 32'h0,         1'b0, 4'd5},  // R5
    '{1'b0, 12'h04C, 32'h0,         32'hA5A5_0F0F, 1'b0, 4'd5},  // R5
    '{1'b1, 12'h004, 32'h0000_1234, 32'h0,         1'b0, 4'd4},  // R4 present
    '{1'b0, 12'h004, 32'h0,         32'h0000_1234, 1'b0, 4'd4},  // R4
    '{1'b0, 12'h00C, 32'h0,         32'h0,         1'b1, 4'd6},  // R6 hole read
    '{1'b1, 12'h100, 32'hDEAD_BEEF, 32'h0,         1'b1, 4'd6},  // R6 hole write
    '{1'b0, 12'h04C, 32'h0,         32'hA5A5_0F0F, 1'b0, 4'd6},  // R6 no effect
    '{1'b1, 12'h04E, 32'h0000_0000, 32'h0,         1'b1, 4'd6},  // R6 misaligned
    '{1'b0, 12'h000, 32'h0,         32'h3,         1'b0, 4'd6},  // R6 LED untouched
    '{1'b0, 12'hFFC, 32'h0,         32'h0,         1'b1, 4'd1}   // R1 window top
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge
  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rdata in reset", rdata_a, 32'h0);
    chk("R10 err in reset", {31'h0, err_a}, 32'h0);
    chk("R10 led in reset", {30'h0, led_a}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    do_rd(12'h010); chk("R10 1Hz counter cleared", rdata_a, 32'h0);
    do_rd(12'h014); chk("R10 100Hz counter cleared", rdata_a, 32'h0);
    do_rd(12'h04C); chk("R10 misc cleared", rdata_a, 32'h0);
    do_rd(12'h004); chk("R10 debug cleared", rdata_a, 32'h0);
    do_rd(12'h000); chk("R10 LED word cleared", rdata_a, 32'h0);

    // Table walk on the full build
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].wr) do_wr(VECS[i].addr, VECS[i].data);
      else begin
        do_rd(VECS[i].addr);
        chk({tag, " rdata"}, rdata_a, VECS[i].exp);
      end
      chk({tag, " err"}, {31'h0, err_a}, {31'h0, VECS[i].err});
      @(negedge clk);
      chk({tag, " err one cycle"}, {31'h0, err_a}, 32'h0);
    end
    chk("R2 led pins", {30'h0, led_a}, 32'h3);
    do_wr(12'h000, 32'h0000_0002);
    chk("R2 led pin 1 only", {30'h0, led_a}, 32'h2);

    // R3 no LEDs on the reduced build
    do_wr(12'h000, 32'hFFFF_FFFF);
    chk("R3 led pin stays low", {31'h0, led_b}, 32'h0);
    do_rd(12'h000);
    chk("R3 LED word reads zero", rdata_b, 32'h0);
    chk("R3 no error", {31'h0, err_b}, 32'h0);

    // R4 absent options fault on reduced build
    do_rd(12'h004);
    chk("R4 debug absent err", {31'h0, err_b}, 32'h1);
    chk("R4 debug absent data", rdata_b, 32'h0);

    // R9 synchronized inputs
    btn = 2'b10; sw = 4'b1011;
    idle(3);
    do_rd(12'h008); chk("R9 buttons", rdata_a, 32'h2);
    do_rd(12'h028); chk("R9 switches", rdata_a, 32'hB);
    chk("R4 switches absent err", {31'h0, err_b}, 32'h1);
    chk("R4 switches absent data", rdata_b, 32'h0);

    // R7 100 Hz rate: 10 cycles per step, read edge 25 after write edge
    do_wr(12'h014, 32'd5);
    idle(24);
    do_rd(12'h014); chk("R7 100Hz after 25 edges", rdata_a, 32'd7);

    // R8 divider restart: edge 10 still old, edge 11 stepped
    do_wr(12'h014, 32'd0);
    idle(9);
    do_rd(12'h014); chk("R8 last cycle before step", rdata_a, 32'd0);
    do_rd(12'h014); chk("R8 first cycle after step", rdata_a, 32'd1);

    // R7 1 Hz rate: 1000 cycles per step
    do_wr(12'h010, 32'd100);
    idle(2498);
    do_rd(12'h010); chk("R7 1Hz after 2499 edges", rdata_a, 32'd102);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule